// File: doc/BRIEF.md
# Multi-format synchronous serial master

This block is the transmit and receive engine of a synchronous serial port that runs as bus master. The host presents one parallel word at a time through a valid/ready handshake, together with a word length, a clock divider and a format code. The engine then produces the serial clock, the frame or select line and the serial data out, and shifts the serial data in back into a parallel word that is announced by a one-cycle strobe.

A single shift path serves three framing styles. In the SPI-style format (clock idle low, data launched before the first rising edge) the select is active low for the whole word. In the frame-pulse format a high pulse one bit long precedes each word and consecutive words can run without a gap. In the Microwire-style format a short command is sent, the line turns around for one bit and a reply of the programmed length is read back. Configuration is captured when a word is accepted, so the host may change it freely while a word is in flight.

Top module: `sync_serial_master`

## Requirements
- R1: After reset sclk is low, frame is high, sdo is low, rx_valid is low, rx_data is zero and tx_ready is high.
- R2: The word length N is cfg_size clamped to the range 4 to 16 (below 4 gives 4, above 16 gives 16); a word carries exactly N data bits, taken from tx_data[N-1:0] and sent highest bit first; the other tx_data bits have no effect.
- R3: One bit lasts 2*(D+1) clock cycles, D being cfg_div with 0 treated as 1; sclk changes only at half-bit boundaries, stays low while idle and sdo is low while idle.
- R4: With cfg_fmt 0 (and the unused code 3) the SPI-style format runs: frame goes low in the first cycle after acceptance and stays low for N bits plus one trailing bit with sclk low; each bit has sclk low in its first half and high in its second, sdo changes at bit starts and sdi is sampled at the rising sclk edge; frame is high while idle.
- R5: With cfg_fmt 1 the frame-pulse format runs: frame is high for one clocked bit before the word and low during the data bits; each bit has sclk high in its first half, so sdo changes on the rising edge and sdi is sampled on the falling edge; frame is low while idle.
- R6: With cfg_fmt 2 the Microwire-style format runs: tx_data[7:0] is sent highest bit first as the command, one clocked turnaround bit follows, then N reply bits are sampled on rising sclk while sdo stays low, then one trailing bit with sclk low; frame is low throughout and high while idle.
- R7: In the frame-pulse format tx_ready is high for the last cycle of the second-to-last data bit; a word accepted then raises frame for the whole last bit and its first data bit follows the last bit with no gap and no extra pulse, reusing the running word's length and divider.
- R8: The received word is right-aligned in rx_data with the upper bits zero; rx_valid is high for exactly one cycle, the cycle after the edge that samples the last reply bit, and rx_data holds the word in that cycle.
- R9: tx_ready is high whenever no word is in flight and low otherwise except for the R7 window; a word is accepted on a clock edge with tx_valid and tx_ready both high, and cfg_fmt, cfg_size and cfg_div are used only at acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Format code: 0 SPI-style, 1 frame pulse, 2 Microwire-style, 3 as 0 |
| cfg_size | input | 5 | Word length in bits, clamped to 4..16 |
| cfg_div | input | 8 | Divider D, half bit = D+1 cycles, 0 read as 1 |
| tx_data | input | 16 | Word to send (command in bits 7:0 for Microwire-style) |
| tx_valid | input | 1 | Host offers tx_data |
| tx_ready | output | 1 | Engine takes tx_data on this edge when tx_valid is high |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe: rx_data is complete |
| sclk | output | 1 | Serial clock |
| frame | output | 1 | Frame pulse or active-low select, per format |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with its defaults: a 16-bit word limit, an 8-bit divider field, an 8-bit command and gapless chaining enabled. With those values it reaches both ends of the length range and beyond them through clamping, divider settings of 0 to 3 so that half bits of two to four cycles are checked against the reference timeline, and a chained pair of frame-pulse words whose handover window exists only because chaining is built in. Every cycle of every word is predicted by a behavioural timeline built from the requirements and compared on all outputs.

// File: rtl/ssm_pkg.sv
`timescale 1ns/1ps
package ssm_pkg;

   typedef enum logic [1:0] {
      FMT_SPI   = 2'd0,
      FMT_SSI   = 2'd1,
      FMT_MWIRE = 2'd2
   } fmt_e;

   typedef enum logic [2:0] {
      K_IDLE,
      K_PULSE,
      K_DATA,
      K_CTRL,
      K_TA,
      K_RESP,
      K_TAIL
   } slot_e;

endpackage

// File: rtl/ssm_halftick.sv
`timescale 1ns/1ps
module ssm_halftick #(
   parameter int DIVW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [DIVW-1:0] div,
   output logic            half_end
);

   logic [DIVW-1:0] cnt;

   assign half_end = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!run || half_end) cnt <= '0;
      else                       cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/ssm_txshift.sv
`timescale 1ns/1ps
module ssm_txshift #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   input  logic          shift,
   output logic          msb
);

   logic [DW-1:0] sh;

   assign msb = sh[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '0;
      else if (load)  sh <= load_val;
      else if (shift) sh <= {sh[DW-2:0], 1'b0};
   end

endmodule

// File: rtl/ssm_rxshift.sv
`timescale 1ns/1ps
module ssm_rxshift #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          sample,
   input  logic          bit_in,
   output logic [DW-1:0] word
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word <= '0;
      else if (clr)    word <= '0;
      else if (sample) word <= {word[DW-2:0], bit_in};
   end

endmodule

// File: rtl/sync_serial_master.sv
`timescale 1ns/1ps
module sync_serial_master
   import ssm_pkg::*;
#(
   parameter int  DW       = 16,
   parameter int  DIVW     = 8,
   parameter int  CTRL_W   = 8,
   parameter int  MIN_SIZE = 4,
   parameter bit  CHAIN_EN = 1'b1,
   localparam int SZW      = $clog2(DW + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cfg_fmt,
   input  logic [SZW-1:0]  cfg_size,
   input  logic [DIVW-1:0] cfg_div,
   input  logic [DW-1:0]   tx_data,
   input  logic            tx_valid,
   output logic            tx_ready,
   output logic [DW-1:0]   rx_data,
   output logic            rx_valid,
   output logic            sclk,
   output logic            frame,
   output logic            sdo,
   input  logic            sdi
);

   localparam int SLW = $clog2(DW + CTRL_W + 3);

   if (DW < MIN_SIZE || MIN_SIZE < 2) begin : g_bad_size
      $error("sync_serial_master: DW must be at least MIN_SIZE, MIN_SIZE at least 2");
   end
   if (CTRL_W > DW || CTRL_W < 1) begin : g_bad_ctrl
      $error("sync_serial_master: CTRL_W must lie in 1..DW");
   end
   if (DIVW < 1) begin : g_bad_div
      $error("sync_serial_master: DIVW must be at least 1");
   end

   // latched state
   logic            busy, half, chain;
   fmt_e            fmt_q;
   logic [SZW-1:0]  size_q;
   logic [DIVW-1:0] div_q;
   logic [SLW-1:0]  slot;
   logic [DW-1:0]   nxt;

   // decoded inputs
   fmt_e            fmt_in;
   logic [SZW-1:0]  size_in;
   logic [DIVW-1:0] div_in;

   // control
   logic            half_end, mid_edge, slot_end, last_slot;
   logic            accept, chain_ready, chain_acc;
   logic            load, shift, sample, tx_msb;
   logic [DW-1:0]   data_al, ctrl_al, load_val;
   logic [SLW-1:0]  n_sl, last_idx, rx_last_idx;
   slot_e           kind;

   always_comb begin
      unique case (cfg_fmt)
         2'd1:    fmt_in = FMT_SSI;
         2'd2:    fmt_in = FMT_MWIRE;
         default: fmt_in = FMT_SPI;
      endcase
      if (cfg_size < SZW'(MIN_SIZE))  size_in = SZW'(MIN_SIZE);
      else if (cfg_size > SZW'(DW))   size_in = SZW'(DW);
      else                            size_in = cfg_size;
      div_in = (cfg_div == '0) ? DIVW'(1) : cfg_div;
   end

   // slot map per format
   assign n_sl = SLW'(size_q);

   always_comb begin
      unique case (fmt_q)
         FMT_MWIRE: begin
            last_idx    = n_sl + SLW'(CTRL_W + 1);
            rx_last_idx = n_sl + SLW'(CTRL_W);
         end
         FMT_SSI: begin
            last_idx    = n_sl;
            rx_last_idx = n_sl;
         end
         default: begin
            last_idx    = n_sl;
            rx_last_idx = n_sl - SLW'(1);
         end
      endcase
   end

   always_comb begin
      if (!busy) kind = K_IDLE;
      else begin
         unique case (fmt_q)
            FMT_SSI:   kind = (slot == '0) ? K_PULSE : K_DATA;
            FMT_MWIRE: begin
               if (slot < SLW'(CTRL_W))        kind = K_CTRL;
               else if (slot == SLW'(CTRL_W))  kind = K_TA;
               else if (slot <= rx_last_idx)   kind = K_RESP;
               else                            kind = K_TAIL;
            end
            default:   kind = (slot < n_sl) ? K_DATA : K_TAIL;
         endcase
      end
   end

   ssm_halftick #(.DIVW(DIVW)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .div      (div_q),
      .half_end (half_end)
   );

   assign mid_edge  = half_end && !half;
   assign slot_end  = half_end && half;
   assign last_slot = (slot == last_idx);

   // handshake, with optional gapless chaining in the frame-pulse format
   if (CHAIN_EN) begin : g_chain
      assign chain_ready = busy && (fmt_q == FMT_SSI) && !chain &&
                           (slot == n_sl - SLW'(1)) && slot_end;
   end else begin : g_nochain
      assign chain_ready = 1'b0;
   end

   assign accept    = !busy && tx_valid;
   assign tx_ready  = !busy || chain_ready;
   assign chain_acc = chain_ready && tx_valid;

   // shifter feed
   assign data_al  = tx_data << (SZW'(DW) - size_in);
   assign ctrl_al  = DW'(tx_data[CTRL_W-1:0]) << (DW - CTRL_W);
   assign load     = accept || (slot_end && last_slot && chain);
   assign load_val = accept ? ((fmt_in == FMT_MWIRE) ? ctrl_al : data_al)
                            : (nxt << (SZW'(DW) - size_q));
   assign shift    = slot_end && (kind == K_DATA || kind == K_CTRL);
   assign sample   = mid_edge && (kind == K_DATA || kind == K_RESP);

   ssm_txshift #(.DW(DW)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .shift    (shift),
      .msb      (tx_msb)
   );

   ssm_rxshift #(.DW(DW)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (load),
      .sample (sample),
      .bit_in (sdi),
      .word   (rx_data)
   );

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         half     <= 1'b0;
         chain    <= 1'b0;
         slot     <= '0;
         fmt_q    <= FMT_SPI;
         size_q   <= SZW'(MIN_SIZE);
         div_q    <= DIVW'(1);
         nxt      <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= sample && (slot == rx_last_idx);
         if (accept) begin
            busy   <= 1'b1;
            half   <= 1'b0;
            slot   <= '0;
            fmt_q  <= fmt_in;
            size_q <= size_in;
            div_q  <= div_in;
         end else if (busy) begin
            if (chain_acc) begin
               chain <= 1'b1;
               nxt   <= tx_data;
            end
            if (mid_edge) half <= 1'b1;
            else if (slot_end) begin
               half <= 1'b0;
               if (last_slot) begin
                  if (chain) begin
                     slot  <= SLW'(1);
                     chain <= 1'b0;
                  end else begin
                     busy <= 1'b0;
                  end
               end else begin
                  slot <= slot + SLW'(1);
               end
            end
         end
      end
   end

   // pins
   assign sclk  = busy && (kind != K_TAIL) && ((fmt_q == FMT_SSI) ? !half : half);
   assign frame = (fmt_q == FMT_SSI) ? (kind == K_PULSE || (busy && last_slot && chain))
                                     : !busy;
   assign sdo   = (kind == K_DATA || kind == K_CTRL) && tx_msb;

endmodule

// File: rtl/ssm_checker.sv
`timescale 1ns/1ps
module ssm_checker
   import ssm_pkg::*;
#(
   parameter int CTRL_W = 8,
   parameter int SLW    = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic           tx_valid,
   input logic           tx_ready,
   input logic           rx_valid,
   input logic           sclk,
   input logic           frame,
   input logic           sdo,
   input logic           busy,
   input logic           half_end,
   input fmt_e           fmt_q,
   input logic [SLW-1:0] slot
);

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sclk && !sdo));

   p_sclk_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !half_end) |=> $stable(sclk));

   p_select_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fmt_q != FMT_SSI) |-> !frame);

   p_reply_sdo_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fmt_q == FMT_MWIRE && slot >= SLW'(CTRL_W)) |-> !sdo);

   p_rxv_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_accept_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && tx_valid) |=> busy);

   p_ready_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tx_ready) |-> (fmt_q == FMT_SSI));

endmodule

bind sync_serial_master ssm_checker #(.CTRL_W(CTRL_W), .SLW(SLW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .rx_valid (rx_valid),
   .sclk     (sclk),
   .frame    (frame),
   .sdo      (sdo),
   .busy     (busy),
   .half_end (half_end),
   .fmt_q    (fmt_q),
   .slot     (slot)
);

// File: tb/sync_serial_master_test.sv
`timescale 1ns/1ps
module sync_serial_master_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_fmt = 2'd0;
   logic [4:0]  cfg_size = 5'd8;
   logic [7:0]  cfg_div = 8'd1;
   logic [15:0] tx_data = '0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic [15:0] rx_data;
   logic        rx_valid;
   logic        sclk, frame, sdo;
   logic        sdi = 1'b0;

   always #5 clk = ~clk;

   sync_serial_master uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_fmt  (cfg_fmt),
      .cfg_size (cfg_size),
      .cfg_div  (cfg_div),
      .tx_data  (tx_data),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .rx_data  (rx_data),
      .rx_valid (rx_valid),
      .sclk     (sclk),
      .frame    (frame),
      .sdo      (sdo),
      .sdi      (sdi)
   );

   typedef struct {
      bit          sclk, frame, sdo, sdi, rxv, rdy;
      logic [15:0] rxd;
      string       ftag, dtag;
   } exp_t;

   exp_t q[$];
   bit   idle_frame = 1'b1;
   bit   run_mon = 1'b0;
   int   n_total = 0;
   int   n_fail = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, expv);
      end
   endtask

   task automatic put(input bit sc, input bit fr, input bit d, input bit si, input bit rv,
                      input bit rd, input logic [15:0] rw, input string ft, input string dt);
      exp_t e;
      e.sclk = sc; e.frame = fr; e.sdo = d; e.sdi = si; e.rxv = rv; e.rdy = rd;
      e.rxd = rw; e.ftag = ft; e.dtag = dt;
      q.push_back(e);
   endtask

   // reference timeline per format
   task automatic gen_spi(input int n, input int h, input logic [15:0] tx, input logic [15:0] sl);
      logic [15:0] rw = sl & 16'((32'd1 << n) - 1);
      for (int s = 0; s < n; s++)
         for (int c = 0; c < 2*h; c++)
            put(c >= h, 1'b0, tx[n-1-s], sl[n-1-s], (s == n-1) && (c == h), 1'b0, rw, "R4", "R2");
      for (int c = 0; c < 2*h; c++)
         put(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, rw, "R4", "R4");
      idle_frame = 1'b1;
   endtask

   task automatic gen_ssi(input int n, input int h, input logic [15:0] tx, input logic [15:0] sl,
                          input bit pulse, input bit chained, input string ft);
      logic [15:0] rw = sl & 16'((32'd1 << n) - 1);
      if (pulse)
         for (int c = 0; c < 2*h; c++)
            put(c < h, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, rw, ft, "R5");
      for (int s = 1; s <= n; s++)
         for (int c = 0; c < 2*h; c++)
            put(c < h, (s == n) && chained, tx[n-s], sl[n-s], (s == n) && (c == h),
                (s == n-1) && (c == 2*h-1), rw, ft, "R2");
      idle_frame = 1'b0;
   endtask

   task automatic gen_mw(input int n, input int h, input logic [15:0] tx, input logic [15:0] sl);
      logic [15:0] rw = sl & 16'((32'd1 << n) - 1);
      for (int s = 0; s < 8; s++)
         for (int c = 0; c < 2*h; c++)
            put(c >= h, 1'b0, tx[7-s], 1'b0, 1'b0, 1'b0, rw, "R6", "R6");
      for (int c = 0; c < 2*h; c++)
         put(c >= h, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, rw, "R6", "R6");
      for (int r = 0; r < n; r++)
         for (int c = 0; c < 2*h; c++)
            put(c >= h, 1'b0, 1'b0, sl[n-1-r], (r == n-1) && (c == h), 1'b0, rw, "R6", "R6");
      for (int c = 0; c < 2*h; c++)
         put(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, rw, "R6", "R6");
      idle_frame = 1'b1;
   endtask

   function automatic int clamp_n(input int raw);
      return (raw < 4) ? 4 : ((raw > 16) ? 16 : raw);
   endfunction

   task automatic wait_drain();
      while (q.size() != 0) @(posedge clk);
   endtask

   // one stand-alone word; config is scrambled after acceptance (R9)
   task automatic send(input int fmt, input int size_raw, input int div_raw,
                       input logic [15:0] tx, input logic [15:0] sl);
      int n = clamp_n(size_raw);
      int h = ((div_raw == 0) ? 1 : div_raw) + 1;
      @(negedge clk);
      cfg_fmt = 2'(fmt); cfg_size = 5'(size_raw); cfg_div = 8'(div_raw);
      tx_data = tx; tx_valid = 1'b1;
      chk(tx_ready === 1'b1, "R9", tx_ready, 1);
      @(posedge clk); #1;
      tx_valid = 1'b0;
      cfg_fmt = ~cfg_fmt; cfg_size = 5'd9; cfg_div = 8'd3; tx_data = ~tx;
      if (fmt == 1)      gen_ssi(n, h, tx, sl, 1'b1, 1'b0, "R5");
      else if (fmt == 2) gen_mw(n, h, tx, sl);
      else               gen_spi(n, h, tx, sl);
      wait_drain();
   endtask

   // two frame-pulse words back to back (R7)
   task automatic send_chain(input int n, input int d, input logic [15:0] w1, input logic [15:0] s1,
                             input logic [15:0] w2, input logic [15:0] s2);
      int h = d + 1;
      @(negedge clk);
      cfg_fmt = 2'd1; cfg_size = 5'(n); cfg_div = 8'(d);
      tx_data = w1; tx_valid = 1'b1;
      @(posedge clk); #1;
      gen_ssi(n, h, w1, s1, 1'b1, 1'b1, "R7");
      cfg_size = 5'd15; cfg_div = 8'd4; cfg_fmt = 2'd0;
      tx_data = w2;
      forever begin
         @(negedge clk);
         if (tx_ready === 1'b1) break;
      end
      @(posedge clk); #1;
      tx_valid = 1'b0;
      gen_ssi(n, h, w2, s2, 1'b0, 1'b0, "R7");
      wait_drain();
   endtask

   // per-cycle comparison against the timeline
   always @(negedge clk) begin
      if (run_mon) begin
         exp_t e;
         if (q.size() > 0) e = q.pop_front();
         else begin
            e.sclk = 1'b0; e.frame = idle_frame; e.sdo = 1'b0; e.sdi = 1'b0;
            e.rxv = 1'b0; e.rdy = 1'b1; e.rxd = '0; e.ftag = "R9"; e.dtag = "R3";
         end
         sdi = e.sdi;
         chk(sclk === e.sclk, "R3 sclk", sclk, e.sclk);
         chk(frame === e.frame, {e.ftag, " frame"}, frame, e.frame);
         chk(sdo === e.sdo, {e.dtag, " sdo"}, sdo, e.sdo);
         chk(rx_valid === e.rxv, "R8 rx_valid", rx_valid, e.rxv);
         chk(tx_ready === e.rdy, "R9 tx_ready", tx_ready, e.rdy);
         if (e.rxv) chk(rx_data === e.rxd, "R8 rx_data", rx_data, e.rxd);
      end
   end

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            // R1 reset state
            chk(sclk === 1'b0, "R1 sclk", sclk, 0);
            chk(frame === 1'b1, "R1 frame", frame, 1);
            chk(sdo === 1'b0, "R1 sdo", sdo, 0);
            chk(rx_valid === 1'b0, "R1 rx_valid", rx_valid, 0);
            chk(rx_data === 16'h0, "R1 rx_data", rx_data, 0);
            chk(tx_ready === 1'b1, "R1 tx_ready", tx_ready, 1);
            run_mon = 1'b1;
            // R4 SPI-style words, R2 MSB first, R3 bit period
            send(0, 8, 1, 16'hFFA5, 16'h003C);
            send(0, 16, 2, 16'hBEEF, 16'h1234);
            send(0, 4, 3, 16'h0009, 16'h0006);
            send(3, 5, 1, 16'hFF15, 16'h000B);
            // R5 frame-pulse words
            send(1, 8, 1, 16'h00C3, 16'h0081);
            send(1, 12, 2, 16'hFA5C, 16'h0A71);
            // R7 chained frame-pulse words
            send_chain(6, 1, 16'h002D, 16'h0033, 16'h0012, 16'h002A);
            send_chain(16, 2, 16'h8001, 16'h7FFE, 16'hC3A5, 16'h5A3C);
            // R6 Microwire-style exchanges
            send(2, 8, 1, 16'hFF96, 16'h005A);
            send(2, 16, 2, 16'h1234, 16'hF00F);
            send(2, 4, 1, 16'h0001, 16'h000D);
            // R2 size clamping, R3 divider zero
            send(0, 2, 1, 16'hFFFA, 16'h0005);
            send(0, 20, 1, 16'h9C3E, 16'hE1C7);
            send(1, 0, 0, 16'h0007, 16'h0008);
            send(0, 6, 0, 16'h0025, 16'h001A);
            repeat (4) @(negedge clk);
         end
         begin
            repeat (200000) @(posedge clk);
            n_fail++;
            n_total++;
            $display("FAIL watchdog: actual=running expected=finished");
         end
      join_any
      run_mon = 1'b0;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule